// File: doc/BRIEF.md
# Fast Ethernet MLT-3 Transmit Line Encoder

This block turns transmit nibbles into the three-level symbol stream of a 100 Mb/s twisted-pair link. It runs entirely on the 125 MHz bit clock. From that clock it derives a 25 MHz nibble clock, `txc_o`, at an exact 5:1 ratio. On the bit-clock edge where `txc_o` rises, it takes one nibble together with its enable.

Each captured nibble becomes a 5-bit code group under the standard 4B/5B data mapping. When the enable is low, the block sends the all-ones idle group instead. The code group is shifted out one bit per clock with the most significant bit first, and there are no gaps between groups. The serial stream is NRZI-coded, and each NRZI transition advances a four-step level cycle.

The level is presented as a 2-bit two's-complement code, ready for an external line driver. Scrambling, analog drive and clock generation are handled elsewhere.

Top module: `mlt3_tx_encoder`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `level_o` is 0 and `nrzi_o` is 0. The first code group sent after reset is idle (11111).
- R2: `txc_o` has a period of 5 clocks. It is high for 3 cycles and low for 2. It is high in the first cycle after reset. The nibble is captured on the clock edge where `txc_o` goes from low to high.
- R3: With `tx_en_i` high at capture, `txd_i` is sent as its 4B/5B group (hex nibble to group, bits 4..0): 0 is 11110, 1 is 01001, 2 is 10100, 3 is 10101, 4 is 01010, 5 is 01011, 6 is 01110, 7 is 01111, 8 is 10010, 9 is 10011, A is 10110, B is 10111, C is 11010, D is 11011, E is 11100, F is 11101.
- R4: With `tx_en_i` low at capture, the group 11111 is sent and `txd_i` has no effect.
- R5: Group bits are sent one per clock, bit 4 first. The bit sent in the 5 cycles after a capture edge belongs to that capture. Groups follow each other with no gap.
- R6: `nrzi_o` toggles at the clock edge that ends a cycle whose serial bit is 1. It holds at the edge that ends a cycle whose serial bit is 0.
- R7: `level_o` steps through 0, +1, 0, -1 and repeats. It takes one step at the clock edge that follows each cycle in which `nrzi_o` differs from its value in the previous cycle. Otherwise it holds, so it never moves directly between +1 and -1.
- R8: `level_o` encodes 0 as 00, +1 as 01 and -1 as 11. It never takes the value 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 125 MHz bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable, sampled at the capture edge |
| txd_i | input | 4 | Transmit nibble, sampled at the capture edge |
| txc_o | output | 1 | Derived 25 MHz nibble clock |
| nrzi_o | output | 1 | NRZI-coded serial stream |
| level_o | output | 2 | Line level code: 00 for 0, 01 for +1, 11 for -1 |

## Verification
The assertions assume that `tx_en_i` and `txd_i` are stable across each capture edge. They place no other demand on the inputs, because any nibble and any enable value is legal. The stimulus changes the inputs only at falling edges and holds each nibble for a full 5-cycle slot, so it stays within that assumption. The bench covers all sixteen nibbles, idle with a varying `txd_i`, and long runs of a single group, so that the level cycle wraps many times.

// File: rtl/mlt3_tx_pkg.sv
package mlt3_tx_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned CG_W  = 5;
  localparam int unsigned LVL_W = 2;

  typedef logic [CG_W-1:0]  cg_t;
  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam cg_t IDLE_CG = '1;

  localparam lvl_t LVL_ZERO = 2'b00;
  localparam lvl_t LVL_POS  = 2'b01;
  localparam lvl_t LVL_NEG  = 2'b11;

  // position in the four-step level cycle
  typedef enum logic [1:0] {
    ST_Z_UP = 2'd0,
    ST_POS  = 2'd1,
    ST_Z_DN = 2'd2,
    ST_NEG  = 2'd3
  } mlt_st_e;

  function automatic cg_t enc_4b5b(input nib_t n);
    cg_t c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/nib_serializer.sv
module nib_serializer
  import mlt3_tx_pkg::*;
#(
  parameter int unsigned TXC_HI = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_en_i,
  input  nib_t txd_i,
  output logic txc_o,
  output logic bit_o
);
  localparam int unsigned SLOT_W = $clog2(CG_W);
  localparam int unsigned LAST   = CG_W - 1;

  logic [SLOT_W-1:0] slot_q;
  cg_t               shreg_q;
  logic              load;

  assign load = (slot_q == SLOT_W'(LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      shreg_q <= IDLE_CG;
    end else if (load) begin
      slot_q  <= '0;
      shreg_q <= tx_en_i ? enc_4b5b(txd_i) : IDLE_CG;
    end else begin
      slot_q  <= slot_q + 1'b1;
      shreg_q <= {shreg_q[CG_W-2:0], 1'b0};
    end
  end

  assign bit_o = shreg_q[CG_W-1];
  assign txc_o = (slot_q < SLOT_W'(TXC_HI));

  // R2
  slot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= SLOT_W'(LAST));

  // R2
  txc_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> $rose(txc_o));

  // R4
  idle_first_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !tx_en_i) |=> bit_o);
endmodule

// File: rtl/nrzi_enc.sv
module nrzi_enc (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  output logic nrzi_o
);
  logic nrzi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nrzi_q <= 1'b0;
    else if (bit_i) nrzi_q <= ~nrzi_q;
  end

  assign nrzi_o = nrzi_q;

  // R6
  one_toggles_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_i |=> (nrzi_o != $past(nrzi_o)));

  // R6
  zero_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_i |=> $stable(nrzi_o));
endmodule

// File: rtl/mlt3_seq.sv
module mlt3_seq
  import mlt3_tx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nrzi_i,
  output lvl_t level_o
);
  logic    nrzi_d_q;
  logic    step;
  mlt_st_e st_q;

  assign step = nrzi_i ^ nrzi_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nrzi_d_q <= 1'b0;
      st_q     <= ST_Z_UP;
    end else begin
      nrzi_d_q <= nrzi_i;
      if (step) st_q <= mlt_st_e'(st_q + 2'd1);
    end
  end

  always_comb begin
    case (st_q)
      ST_POS:  level_o = LVL_POS;
      ST_NEG:  level_o = LVL_NEG;
      default: level_o = LVL_ZERO;
    endcase
  end

  // R8
  level_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o != 2'b10);

  // R7
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step |=> $stable(level_o));

  // R7
  no_rail_jump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(level_o) |-> ($past(level_o) == LVL_ZERO || level_o == LVL_ZERO));
endmodule

// File: rtl/mlt3_tx_encoder.sv
module mlt3_tx_encoder
  import mlt3_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tx_en_i,
  input  logic [3:0] txd_i,
  output logic       txc_o,
  output logic       nrzi_o,
  output logic [1:0] level_o
);
  logic ser_bit;

  nib_serializer #(.TXC_HI(3)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tx_en_i (tx_en_i),
    .txd_i   (txd_i),
    .txc_o   (txc_o),
    .bit_o   (ser_bit)
  );

  nrzi_enc u_nrzi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (ser_bit),
    .nrzi_o (nrzi_o)
  );

  mlt3_seq u_mlt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .nrzi_i  (nrzi_o),
    .level_o (level_o)
  );

  // R2
  txc_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(txc_o) |=> !txc_o);
endmodule

// File: tb/mlt3_tx_encoder_tb_top.sv
module mlt3_tx_encoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic [3:0] txd = 4'h0;
  logic       txc;
  logic       nrzi;
  logic [1:0] level;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference model state
  bit bitq[$];
  int slot;
  int mpos;
  bit nrzi_e;
  bit prev_tog;
  bit prev_bit;
  bit have_prev;
  logic prev_nrzi;

  always #4 clk = ~clk;

  mlt3_tx_encoder dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .tx_en_i (tx_en),
    .txd_i   (txd),
    .txc_o   (txc),
    .nrzi_o  (nrzi),
    .level_o (level)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] grp(input bit en, input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return en ? t[n] : 5'b11111;
  endfunction

  function automatic logic [1:0] lvl_exp(input int p);
    if (p == 1) return 2'b01;
    if (p == 3) return 2'b11;
    return 2'b00;
  endfunction

  // compare now, drive inputs for the next edge, advance model, wait a cycle
  task automatic cycle(input bit en, input logic [3:0] d, input string req);
    bit b;
    chk(txc === (slot < 3), "R2", "txc", int'(txc), int'(slot < 3));
    chk(nrzi === nrzi_e, req, "nrzi", int'(nrzi), int'(nrzi_e));
    chk(level === lvl_exp(mpos), "R7", "level", int'(level), int'(lvl_exp(mpos)));
    chk(level !== 2'b10, "R8", "level code", int'(level), 0);
    if (have_prev)
      chk((nrzi ^ prev_nrzi) === prev_bit, "R5", "serial bit",
          int'(nrzi ^ prev_nrzi), int'(prev_bit));
    tx_en = en;
    txd = d;
    b = bitq.pop_front();
    prev_bit = b;
    prev_nrzi = nrzi;
    have_prev = 1'b1;
    if (prev_tog) mpos = (mpos + 1) % 4;
    prev_tog = b;
    if (b) nrzi_e = ~nrzi_e;
    if (slot == 4) begin
      logic [4:0] g;
      g = grp(en, d);
      for (int i = 4; i >= 0; i--) bitq.push_back(g[i]);
    end
    slot = (slot + 1) % 5;
    @(negedge clk);
  endtask

  task automatic send(input bit en, input logic [3:0] d, input string req);
    for (int i = 0; i < 5; i++) cycle(en, d, req);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(level === 2'b00, "R1", "level in reset", int'(level), 0);
    chk(nrzi === 1'b0, "R1", "nrzi in reset", int'(nrzi), 0);
    rst_n = 1'b1;
    chk(level === 2'b00, "R1", "level after reset", int'(level), 0);
    chk(nrzi === 1'b0, "R1", "nrzi after reset", int'(nrzi), 0);
    chk(txc === 1'b1, "R2", "txc after reset", int'(txc), 1);
    for (int i = 0; i < 5; i++) bitq.push_back(1'b1);
    slot = 0; mpos = 0; nrzi_e = 0; prev_tog = 0; have_prev = 0;

    // R1: first group is idle regardless of inputs
    send(1'b1, 4'h0, "R1");
    // R4: idle with txd moving
    for (int i = 0; i < 6; i++) send(1'b0, 4'(i * 5 + 3), "R4");
    // R3: every nibble
    for (int i = 0; i < 16; i++) send(1'b1, 4'(i), "R3");
    // R3: reverse order, interleaved with idle
    for (int i = 15; i >= 0; i--) begin
      send(1'b1, 4'(i), "R3");
      if (i % 4 == 0) send(1'b0, 4'hF, "R4");
    end
    // R7: long runs so the level cycle wraps repeatedly
    for (int i = 0; i < 12; i++) send(1'b1, 4'h7, "R7");
    for (int i = 0; i < 12; i++) send(1'b1, 4'h1, "R6");
    for (int i = 0; i < 10; i++) send(1'b0, 4'h0, "R6");
    // R5: mixed pattern
    for (int i = 0; i < 40; i++) send(((i % 3) != 0), 4'((i * 7) % 16), "R5");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule